// File: doc/BRIEF.md
# Push-Pull Two-Wire Serial Engine

This engine carries one single-byte register access at a time to a single peripheral over a clock line and a data line. Its host side is a one-cycle start pulse with a read/write flag, an 8-bit register address and an 8-bit write byte. The frame has no device address and no acknowledge slot. An even parity bit follows each byte. A read is one access: the address goes out, and the engine then releases the data line and shifts in the byte and its parity within the same frame.

The data line is driven push-pull. It is released only while the peripheral returns read data. The bus clock comes from the system clock through an 8-bit divider. A 3-bit delay setting places each data-line change a chosen number of system cycles after the falling clock edge. The end of an access shows as a one-cycle done pulse. A read with a parity mismatch also shows a one-cycle error pulse.

Top module: `pp2w_engine`

## Requirements
- R1: After reset and between accesses, the clock output is high, the data output is driven (`sda_oe_o`=1) at 1, and both `done_o` and `err_o` are low.
- R2: The divider setting is taken as E = max(`div_i`, 1). An access opens with a start condition: the data line falls while the clock is high. The clock then falls E+1 system cycles later.
- R3: The frame holds exactly 18 bits, MSB first. They are the address byte, its parity, the data byte and its parity. No device address or acknowledge bit is sent. Each parity bit is the XOR of the 8 bits before it, which gives even parity. The data line is stable while the clock is high, and each bit is sampled on the rising clock edge.
- R4: In a read (`rd_i`=1), `sda_oe_o` is 0 during bits 9 to 17, which are the data byte and its parity. Those bits are sampled from `sda_i`. At done, the byte received appears on `rdata_o`.
- R5: Within a frame, every clock low half and every clock high half lasts E+1 system cycles.
- R6: The delay is taken as D = min(`dly_i`, E-1). A change of the driven data line during a low clock half occurs D+1 system cycles after the clock falls.
- R7: After bit 17, the data line is driven low during one clock low half. The clock then rises, and the data line rises E+1 cycles later, which is the stop condition. `done_o` pulses for exactly one cycle, in the same cycle as the stop.
- R8: In a read, if the received parity differs from the XOR of the received byte, `err_o` pulses together with `done_o`, and the byte is still reported. A write never raises `err_o`.
- R9: A start pulse that arrives while an access is in progress is ignored. The current frame is not altered and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an access |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Byte to write |
| div_i | input | 8 | Clock divider setting (0 acts as 1) |
| dly_i | input | 3 | Data-change delay after clock fall, in system cycles |
| scl_o | output | 1 | Bus clock |
| sda_o | output | 1 | Data line output value |
| sda_oe_o | output | 1 | Data line output enable |
| sda_i | input | 1 | Data line as seen on the bus |
| rdata_o | output | 8 | Byte captured by the last read |
| done_o | output | 1 | One-cycle end-of-access pulse |
| err_o | output | 1 | One-cycle read parity error pulse |

## Verification
The bench builds the engine with its default 8-bit address, data and divider widths and the 3-bit delay. It sweeps the divider over 0 to 3 against all eight delay values, for both reads and writes. In this range the delay clamp to E-1 comes into effect, and a zero divider must behave like one. Further accesses use divider 9 with the largest delay, where no clamp applies, and divider 255, the longest half period. A peripheral model returns read data with correct or deliberately corrupted parity, and one access receives a second start pulse in the middle of its frame.

// File: rtl/pp2w_pkg.sv
package pp2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BLO,
    ST_BHI,
    ST_PLO,
    ST_PHI
  } pp2w_st_t;
endpackage

// File: rtl/pp2w_halfper.sv
module pp2w_halfper #(
  parameter int DIV_W = 8,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             at_dly,
  output logic             at_end
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] dly_ext;
  logic [DIV_W-1:0] dly_eff;

  always_comb begin
    div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    dly_ext = {{(DIV_W-DLY_W){1'b0}}, dly_i};
    dly_eff = (dly_ext >= div_eff) ? (div_eff - DIV_W'(1)) : dly_ext;
  end

  assign at_end = (cnt == div_eff);
  assign at_dly = (cnt == dly_eff);

  always_ff @(posedge clk) begin
    if (rst || !run || at_end) cnt <= '0;
    else                       cnt <= cnt + DIV_W'(1);
  end

  // R5: the half-period counter never passes its end value
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= div_eff);
endmodule

// File: rtl/pp2w_frame.sv
module pp2w_frame #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int NB = AW + DW + 2,
  localparam int IW = $clog2(NB)
) (
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic [IW-1:0] idx_i,
  output logic          bit_o,
  output logic          drive_o
);
  logic [NB-1:0] frame;
  assign frame   = {addr_i, ^addr_i, wdata_i, ^wdata_i};
  assign bit_o   = frame[IW'(NB-1) - idx_i];
  assign drive_o = !rd_i || (idx_i < IW'(AW + 1));
endmodule

// File: rtl/pp2w_rxchk.sv
module pp2w_rxchk #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_i,
  input  logic          din_i,
  output logic [DW-1:0] byte_o,
  output logic          par_bad_o
);
  logic [DW:0] sh;

  always_ff @(posedge clk) begin
    if (rst)           sh <= '0;
    else if (sample_i) sh <= {sh[DW-1:0], din_i};
  end

  assign byte_o    = sh[DW:1];
  assign par_bad_o = ^sh;
endmodule

// File: rtl/pp2w_engine.sv
module pp2w_engine #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DIV_W = 8,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             sda_oe_o,
  input  logic             sda_i,
  output logic [DW-1:0]    rdata_o,
  output logic             done_o,
  output logic             err_o
);
  import pp2w_pkg::*;
  localparam int NB = AW + DW + 2;
  localparam int IW = $clog2(NB);

  pp2w_st_t         st;
  logic             rd_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wd_q;
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] dly_q;
  logic [IW-1:0]    idx;
  logic             at_dly, at_end;
  logic             tx_bit, tx_drive;
  logic             rx_sample;
  logic [DW-1:0]    rx_byte;
  logic             rx_bad;

  pp2w_halfper #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_hp (
    .clk(clk), .rst(rst), .run(st != ST_IDLE),
    .div_i(div_q), .dly_i(dly_q), .at_dly(at_dly), .at_end(at_end)
  );

  pp2w_frame #(.AW(AW), .DW(DW)) u_fr (
    .addr_i(addr_q), .wdata_i(wd_q), .rd_i(rd_q), .idx_i(idx),
    .bit_o(tx_bit), .drive_o(tx_drive)
  );

  assign rx_sample = (st == ST_BLO) && at_end && !sda_oe_o;

  pp2w_rxchk #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .sample_i(rx_sample), .din_i(sda_i),
    .byte_o(rx_byte), .par_bad_o(rx_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      div_q    <= DIV_W'(1);
      dly_q    <= '0;
      idx      <= '0;
      scl_o    <= 1'b1;
      sda_o    <= 1'b1;
      sda_oe_o <= 1'b1;
      rdata_o  <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          rd_q   <= rd_i;
          addr_q <= addr_i;
          wd_q   <= wdata_i;
          div_q  <= div_i;
          dly_q  <= dly_i;
          sda_o  <= 1'b0;
          st     <= ST_START;
        end
        ST_START: if (at_end) begin
          scl_o <= 1'b0;
          idx   <= '0;
          st    <= ST_BLO;
        end
        ST_BLO: begin
          if (at_dly) begin
            sda_o    <= tx_drive ? tx_bit : 1'b1;
            sda_oe_o <= tx_drive;
          end
          if (at_end) begin
            scl_o <= 1'b1;
            st    <= ST_BHI;
          end
        end
        ST_BHI: if (at_end) begin
          scl_o <= 1'b0;
          if (idx == IW'(NB-1)) st <= ST_PLO;
          else begin
            idx <= idx + IW'(1);
            st  <= ST_BLO;
          end
        end
        ST_PLO: begin
          if (at_dly) begin
            sda_o    <= 1'b0;
            sda_oe_o <= 1'b1;
          end
          if (at_end) begin
            scl_o <= 1'b1;
            st    <= ST_PHI;
          end
        end
        ST_PHI: if (at_end) begin
          sda_o  <= 1'b1;
          done_o <= 1'b1;
          err_o  <= rd_q && rx_bad;
          if (rd_q) rdata_o <= rx_byte;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: idle bus is clock high, data driven high
  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (scl_o && sda_o && sda_oe_o));
  // R3: data line holds while the clock stays high inside a bit
  assert_sda_stable_high_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BHI && $past(st) == ST_BHI) |-> $stable(sda_o) && $stable(sda_oe_o));
  // R4: the line is released only during a read
  assert_release_read_R4: assert property (@(posedge clk) disable iff (rst)
    !sda_oe_o |-> rd_q);
  // R7: done lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: error only alongside done of a read
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && rd_q));
  // R9: a start while busy leaves the latched access unchanged
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && $past(st) != ST_IDLE) |-> ($stable(addr_q) && $stable(rd_q)));
endmodule

// File: tb/sim_pp2w_engine.sv
module sim_pp2w_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] div_i = 8'd1;
  logic [2:0] dly_i = '0;
  logic       sda_i = 1'b1;
  logic       scl_o, sda_o, sda_oe_o, done_o, err_o;
  logic [7:0] rdata_o;

  always #10 clk = ~clk;

  pp2w_engine u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .div_i(div_i), .dly_i(dly_i), .scl_o(scl_o),
    .sda_o(sda_o), .sda_oe_o(sda_oe_o), .sda_i(sda_i), .rdata_o(rdata_o),
    .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected access description
  int         de = 1, dle = 0;
  bit         exp_rd = 0;
  logic [8:0] resp = '0;
  logic [17:0] exp_frame = '0;
  int         frames = 0, dones = 0;

  // bus monitor and peripheral model
  bit  in_frame = 0;
  int  bitcnt = 0, hilen = 0, lowlen = 0;
  logic [17:0] cap = '0;
  logic pscl = 1, psda = 1, poe = 1;

  always @(negedge clk) begin
    bit stop_now;
    stop_now = 0;
    if (!rst) begin
      if (scl_o && !pscl) hilen = 1; else if (scl_o) hilen++;
      if (!scl_o && pscl) lowlen = 1; else if (!scl_o) lowlen++;
      if (scl_o && pscl && poe && sda_oe_o && psda && !sda_o) begin
        chk(!in_frame, "R2 start inside frame", in_frame, 0);
        in_frame = 1; bitcnt = 0; cap = '0; hilen = 1; frames++;
      end else if (scl_o && pscl && poe && sda_oe_o && !psda && sda_o && in_frame) begin
        chk(bitcnt == 18, "R7 bits before stop", bitcnt, 18);
        chk(hilen == de + 2, "R7 stop high length", hilen - 1, de + 1);
        chk(cap == exp_frame, "R3 frame bits", int'(cap), int'(exp_frame));
        in_frame = 0; stop_now = 1;
      end
      if (in_frame && scl_o && !pscl) begin
        chk(lowlen == de + 1, "R5 low half length", lowlen, de + 1);
        if (bitcnt < 18) begin
          chk(sda_oe_o == (!exp_rd || bitcnt < 9), "R4 drive enable per bit",
              sda_oe_o, (!exp_rd || bitcnt < 9));
          cap = {cap[16:0], sda_oe_o ? sda_o : sda_i};
          bitcnt++;
        end else begin
          chk(sda_oe_o && !sda_o, "R7 data low before stop", sda_o, 0);
        end
      end
      if (in_frame && !scl_o && pscl) begin
        if (bitcnt == 0) chk(hilen == de + 1, "R2 start to clock fall", hilen, de + 1);
        else             chk(hilen == de + 1, "R5 high half length", hilen, de + 1);
      end
      if (in_frame && !scl_o && !pscl && poe && sda_oe_o && (sda_o != psda))
        chk(lowlen == dle + 2, "R6 data change delay", lowlen - 1, dle + 1);
      if (done_o) begin
        chk(stop_now, "R7 done with stop", 0, 1);
        dones++;
      end
      if (in_frame && !scl_o && exp_rd && bitcnt >= 9 && bitcnt < 18)
        sda_i = resp[17 - bitcnt];
      else
        sda_i = 1'b1;
    end
    pscl = scl_o; psda = sda_o; poe = sda_oe_o;
  end

  task automatic txn(input int dv, input int dy, input bit rd, input logic [7:0] a,
                     input logic [7:0] d, input bit corrupt, input bit poke);
    int f0, d0, w;
    bit got;
    @(negedge clk);
    de  = (dv == 0) ? 1 : dv;
    dle = (dy >= de) ? de - 1 : dy;
    exp_rd = rd;
    resp = {d, (^d) ^ corrupt};
    exp_frame = rd ? {a, ^a, resp} : {a, ^a, d, ^d};
    f0 = frames; d0 = dones;
    div_i = 8'(dv); dly_i = 3'(dy); rd_i = rd; addr_i = a; wdata_i = d;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (7 * (de + 1)) @(negedge clk);
      addr_i = ~a; rd_i = ~rd; div_i = 8'd3; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    got = 0;
    for (w = 0; w < 20000 && !got; w++) begin
      if (done_o) got = 1; else @(negedge clk);
    end
    chk(got, "R7 done seen", got, 1);
    if (got) begin
      chk(err_o == (rd && corrupt), "R8 error flag", err_o, (rd && corrupt));
      if (rd) chk(rdata_o == d, "R4 read byte", rdata_o, d);
      @(negedge clk);
      chk(!done_o && !err_o, "R7 done one cycle", done_o, 0);
    end
    repeat (2 * (de + 1) + 4) @(negedge clk);
    chk(frames == f0 + 1, "R9 frame count", frames - f0, 1);
    chk(dones == d0 + 1, "R9 done count", dones - d0, 1);
    chk(scl_o && sda_o && sda_oe_o, "R1 idle bus", {scl_o, sda_o, sda_oe_o}, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_o && sda_o && sda_oe_o && !done_o && !err_o, "R1 reset state",
        {scl_o, sda_o, sda_oe_o, done_o, err_o}, 5'b11100);
    for (int dv = 0; dv < 4; dv++)
      for (int dy = 0; dy < 8; dy++)
        for (int rw = 0; rw < 2; rw++) begin
          logic [7:0] a, d;
          a = 8'(dv * 67 + dy * 29 + rw * 13) ^ 8'hA5;
          d = 8'(dy * 37 + dv * 91) ^ {a[3:0], a[7:4]};
          txn(dv, dy, rw[0], a, d, rw[0] & dy[0], 1'b0);
        end
    txn(9, 7, 1'b0, 8'h80, 8'h01, 1'b0, 1'b0);   // R6 unclamped delay
    txn(9, 7, 1'b1, 8'h7F, 8'hFE, 1'b1, 1'b0);   // R8 parity error
    txn(255, 5, 1'b0, 8'h3C, 8'hC3, 1'b0, 1'b0); // R5 longest half period
    txn(255, 2, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);
    txn(2, 1, 1'b0, 8'h5A, 8'h96, 1'b0, 1'b1);   // R9 start while busy
    txn(1, 0, 1'b1, 8'hE1, 8'h1E, 1'b0, 1'b1);   // R9 during read
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule